// File: doc/BRIEF.md
# External Interrupt Latch Controller

This block handles one external, active-low interrupt request line for a small CPU. The pin is brought into the clock domain through a chain of flip-flops. A falling edge, or a falling edge together with a held-low level, sets an interrupt latch. A mode bit in the block's single byte-wide status/control register selects between these two triggers.

Software reads the latch as a pending flag and clears it by writing one to an acknowledge bit. A mask bit keeps the latch from reaching the CPU request line. It does not stop the latch from capturing events.

A debug-break input guards the latch. While break is active, acknowledge writes are discarded unless a second input allows clearing during break. A latch cleared that way stays clear after break ends, until a new event arrives. The CPU request output is registered.

Top module: `extirq_ctrl`

## Requirements
- R1: Register read layout: bit 3 is the pending flag, bit 1 the mask, bit 0 the trigger mode. Bits 7..4 and bit 2 (acknowledge) always read 0, whatever was written.
- R2: Reset (rst_n low) clears the latch, mask, mode and the CPU request, so the register reads 0x00 and cpu_irq is 0.
- R3: With mode = 0, only a high-to-low transition of the synchronized pin sets the latch. A pin held low, or a rising edge, does not set it again after an acknowledge.
- R4: With mode = 1, the latch stays set in every cycle the synchronized pin is low, so an acknowledge while the pin is low leaves it set. Once the pin is high, an acknowledge clears it.
- R5: A register write with bit 2 = 1 clears the latch (outside break). A write with bit 2 = 0 leaves it unchanged.
- R6: Mask = 1 forces cpu_irq to 0 from the next cycle on, while the latch still captures events.
- R7: cpu_irq equals the previous cycle's (latch AND NOT mask).
- R8: While brk_active = 1 and brk_clr_en = 0, acknowledge writes do not change the latch.
- R9: While brk_active = 1 and brk_clr_en = 1, an acknowledge write clears the latch, and it stays clear after brk_active returns to 0 when no new edge arrives.
- R10: A falling edge that is detected in the same cycle as an acknowledge write wins, so the latch ends up set.
- R11: A pin change takes effect through two synchronizer flops and one edge register. The pending flag reads 1 after the third rising clock edge that follows a falling pin change, and cpu_irq rises one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select for the bus access |
| reg_wr | input | 1 | Write strobe, taken when reg_sel is 1 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the status/control register |
| pin_n | input | 1 | Asynchronous active-low interrupt pin |
| brk_active | input | 1 | Debug break state is active |
| brk_clr_en | input | 1 | Allows acknowledge writes during break |
| cpu_irq | output | 1 | Registered interrupt request to the CPU |

## Verification
The trigger logic is driven with single falling edges, with a pin held low across acknowledges, and with rising edges. This separates edge-only sensing from edge-plus-level sensing. Acknowledge writes are issued with the mask set and cleared, with break off, with break on and clearing blocked, and with break on and clearing allowed. These cases show whether the latch, the request gating and the break gate act independently. One directed case places a fresh edge in the same cycle as an acknowledge to check that the edge wins. Another samples one edge before and at the expected cycle to pin down the synchronizer latency.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

    // Register bit positions (software-visible layout)
    localparam int PEND_BIT = 3;
    localparam int ACK_BIT  = 2;
    localparam int MASK_BIT = 1;
    localparam int MODE_BIT = 0;

    // Control fields held in flops
    typedef struct packed {
        logic mask;
        logic mode;
    } ctl_t;

    // Interrupt state
    typedef struct packed {
        logic latch;
        logic irq;
    } irq_st_t;

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
    parameter int   SYNC_STAGES = 2,
    parameter logic IDLE_LEVEL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic lvl_low,
    output logic fall
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   prev;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic     synced;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = pin_n;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.prev = st_q.chain[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= {SYNC_STAGES{IDLE_LEVEL}};
            st_q.prev  <= IDLE_LEVEL;
        end else begin
            st_q <= st_d;
        end
    end

    assign synced  = st_q.chain[SYNC_STAGES-1];
    assign lvl_low = ~synced;
    assign fall    = st_q.prev & ~synced;

    // R11: a detected edge lasts exactly one cycle
    a_r11_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
    import extirq_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             brk_active,
    input  logic             brk_clr_en,
    input  logic             pending,
    output logic             mask,
    output logic             mode,
    output logic             ack_eff,
    output logic [REG_W-1:0] reg_rdata
);

    localparam logic [REG_W-1:0] USED_BITS =
        (REG_W'(1) << ACK_BIT) | (REG_W'(1) << MASK_BIT) | (REG_W'(1) << MODE_BIT);

    ctl_t ctl_d, ctl_q;
    logic wr_hit;
    logic unused_wbits;

    assign wr_hit       = reg_sel & reg_wr;
    assign unused_wbits = ^(reg_wdata & ~USED_BITS);

    always_comb begin
        ctl_d = ctl_q;
        if (wr_hit) begin
            ctl_d.mask = reg_wdata[MASK_BIT];
            ctl_d.mode = reg_wdata[MODE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Acknowledge is gated by the break state
    assign ack_eff = wr_hit & reg_wdata[ACK_BIT] & (~brk_active | brk_clr_en);

    always_comb begin
        reg_rdata           = '0;
        reg_rdata[PEND_BIT] = pending;
        reg_rdata[MASK_BIT] = ctl_q.mask;
        reg_rdata[MODE_BIT] = ctl_q.mode;
    end

    assign mask = ctl_q.mask;
    assign mode = ctl_q.mode;

    // R8: no effective acknowledge while break blocks clearing
    a_r8_no_ack_in_break: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_active && !brk_clr_en) |-> !ack_eff);

endmodule

// File: rtl/extirq_latch.sv
module extirq_latch
    import extirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fall,
    input  logic lvl_low,
    input  logic mode,
    input  logic ack,
    input  logic mask,
    output logic pending,
    output logic irq
);

    irq_st_t st_d, st_q;
    logic    set_ev;

    always_comb begin
        set_ev = fall | (mode & lvl_low);
        st_d   = st_q;
        if (set_ev) begin
            st_d.latch = 1'b1;
        end else if (ack) begin
            st_d.latch = 1'b0;
        end
        st_d.irq = st_q.latch & ~mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending = st_q.latch;
    assign irq     = st_q.irq;

    // R3 / R10: an edge always sets the latch, even against an acknowledge
    a_r3_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> pending);

    // R4: level mode keeps the latch set while the pin is low
    a_r4_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && lvl_low) |=> pending);

    // R5: an acknowledge with no competing event clears the latch
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !fall && !(mode && lvl_low)) |=> !pending);

endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
    import extirq_pkg::*;
#(
    parameter int REG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             pin_n,
    input  logic             brk_active,
    input  logic             brk_clr_en,
    output logic             cpu_irq
);

    logic lvl_low;
    logic fall;
    logic mask;
    logic mode;
    logic ack_eff;
    logic pending;

    extirq_sync #(
        .SYNC_STAGES (SYNC_STAGES),
        .IDLE_LEVEL  (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n   (pin_n),
        .lvl_low (lvl_low),
        .fall    (fall)
    );

    extirq_regs #(
        .REG_W (REG_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_sel    (reg_sel),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .brk_active (brk_active),
        .brk_clr_en (brk_clr_en),
        .pending    (pending),
        .mask       (mask),
        .mode       (mode),
        .ack_eff    (ack_eff),
        .reg_rdata  (reg_rdata)
    );

    extirq_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall    (fall),
        .lvl_low (lvl_low),
        .mode    (mode),
        .ack     (ack_eff),
        .mask    (mask),
        .pending (pending),
        .irq     (cpu_irq)
    );

    // R6: a set mask silences the request on the following cycle
    a_r6_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        mask |=> !cpu_irq);

    // R7: request tracks the unmasked latch one cycle later
    a_r7_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !mask) |=> cpu_irq);

    // R8: during protected break the latch cannot drop
    a_r8_break_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_active && !brk_clr_en && pending) |=> pending);

endmodule

// File: tb/sim_extirq_ctrl.sv
module sim_extirq_ctrl;

    typedef struct packed {
        logic       pin;
        logic       brk;
        logic       ce;
        logic       wr;
        logic [7:0] wd;
        logic [3:0] cyc;
        logic [7:0] exp_rd;
        logic       exp_irq;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t TBL [NV] = '{
        '{1'b1,1'b0,1'b0,1'b0,8'h00,4'd2,8'h00,1'b0,4'd2},  // R2 idle after reset
        '{1'b0,1'b0,1'b0,1'b0,8'h00,4'd3,8'h08,1'b0,4'd11}, // R11 pending on 3rd edge
        '{1'b0,1'b0,1'b0,1'b0,8'h00,4'd1,8'h08,1'b1,4'd7},  // R7 irq one later
        '{1'b0,1'b0,1'b0,1'b1,8'h04,4'd2,8'h00,1'b0,4'd5},  // R5 ack clears
        '{1'b1,1'b0,1'b0,1'b0,8'h00,4'd4,8'h00,1'b0,4'd3},  // R3 rising edge ignored
        '{1'b1,1'b0,1'b0,1'b1,8'h02,4'd2,8'h02,1'b0,4'd1},  // R1 mask readback
        '{1'b0,1'b0,1'b0,1'b0,8'h00,4'd4,8'h0A,1'b0,4'd6},  // R6 masked capture
        '{1'b0,1'b0,1'b0,1'b1,8'h00,4'd2,8'h08,1'b1,4'd5},  // R5 bit2=0 no clear
        '{1'b0,1'b0,1'b0,1'b1,8'h01,4'd2,8'h09,1'b1,4'd4},  // R4 level mode on
        '{1'b0,1'b0,1'b0,1'b1,8'h05,4'd2,8'h09,1'b1,4'd4},  // R4 ack while low
        '{1'b1,1'b0,1'b0,1'b0,8'h00,4'd3,8'h09,1'b1,4'd4},  // R4 pin high, held
        '{1'b1,1'b0,1'b0,1'b1,8'h05,4'd2,8'h01,1'b0,4'd4},  // R4 ack when high
        '{1'b1,1'b0,1'b0,1'b1,8'h00,4'd2,8'h00,1'b0,4'd3},  // R3 back to edge
        '{1'b0,1'b1,1'b0,1'b0,8'h00,4'd4,8'h08,1'b1,4'd8},  // R8 edge in break
        '{1'b0,1'b1,1'b0,1'b1,8'h04,4'd2,8'h08,1'b1,4'd8},  // R8 ack blocked
        '{1'b0,1'b1,1'b1,1'b1,8'h04,4'd2,8'h00,1'b0,4'd9},  // R9 ack allowed
        '{1'b0,1'b0,1'b0,1'b0,8'h00,4'd3,8'h00,1'b0,4'd9},  // R9 stays clear
        '{1'b1,1'b0,1'b0,1'b0,8'h00,4'd3,8'h00,1'b0,4'd3},  // R3 pin released
        '{1'b1,1'b0,1'b0,1'b1,8'hF7,4'd2,8'h03,1'b0,4'd1},  // R1 unused bits read 0
        '{1'b1,1'b0,1'b0,1'b1,8'h00,4'd2,8'h00,1'b0,4'd1}   // R1 cleared fields
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       pin_n = 1'b1;
    logic       brk_active = 1'b0;
    logic       brk_clr_en = 1'b0;
    logic       cpu_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    extirq_ctrl u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_sel    (reg_sel),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .pin_n      (pin_n),
        .brk_active (brk_active),
        .brk_clr_en (brk_clr_en),
        .cpu_irq    (cpu_irq)
    );

    task automatic check(input int req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    initial begin
        #80000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(2, "reset rdata", reg_rdata, 8'h00);         // R2
        check(2, "reset irq", {7'b0, cpu_irq}, 8'h00);     // R2
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            pin_n      = TBL[v].pin;
            brk_active = TBL[v].brk;
            brk_clr_en = TBL[v].ce;
            reg_sel    = TBL[v].wr;
            reg_wr     = TBL[v].wr;
            reg_wdata  = TBL[v].wd;
            @(posedge clk);
            @(negedge clk);
            reg_sel   = 1'b0;
            reg_wr    = 1'b0;
            reg_wdata = 8'h00;
            for (int c = 1; c < int'(TBL[v].cyc); c++) begin
                @(negedge clk);
            end
            check(int'(TBL[v].req), $sformatf("step %0d rdata", v), reg_rdata, TBL[v].exp_rd);
            check(int'(TBL[v].req), $sformatf("step %0d irq", v), {7'b0, cpu_irq},
                  {7'b0, TBL[v].exp_irq});
        end

        // R11: one edge early the flag is still clear
        pin_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(11, "pending before 3rd edge", reg_rdata, 8'h00);
        @(negedge clk);
        check(11, "pending at 3rd edge", reg_rdata, 8'h08);

        // R10: fresh edge coincides with acknowledge
        pin_n = 1'b1;
        repeat (4) @(negedge clk);
        check(10, "latch held before race", reg_rdata, 8'h08);
        pin_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        reg_sel   = 1'b1;
        reg_wr    = 1'b1;
        reg_wdata = 8'h04;
        @(posedge clk);
        @(negedge clk);
        reg_sel   = 1'b0;
        reg_wr    = 1'b0;
        reg_wdata = 8'h00;
        check(10, "edge beats ack", reg_rdata, 8'h08);

        // R2: reset in mid-run clears everything
        @(negedge clk);
        check(2, "irq before reset", {7'b0, cpu_irq}, 8'h01);
        reg_sel   = 1'b1;
        reg_wr    = 1'b1;
        reg_wdata = 8'h03;
        @(negedge clk);
        reg_sel   = 1'b0;
        reg_wr    = 1'b0;
        reg_wdata = 8'h00;
        rst_n = 1'b0;
        @(negedge clk);
        check(2, "mid-run reset rdata", reg_rdata, 8'h00);
        check(2, "mid-run reset irq", {7'b0, cpu_irq}, 8'h00);
        pin_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule